// File: doc/BRIEF.md
# Arithmetic Status Flags with Sticky Bits

This block holds the condition flags of a 20-bit signed fixed-point signal-processing datapath. It observes two event streams. The first is the arithmetic unit reporting a finished result. The second is the data shifter reporting a word that passed through it. From these it keeps four instantaneous flags (zero, negative, carry, overflow), a divide quotient bit, and three sticky flags (scaling, limiting, overflow). The sticky flags collect events across many operations until software-level code clears them.

Every strobe is accepted in the cycle it is asserted, because the block never stalls. There is no ready signal and no back-pressure. The producer must present a new event only by asserting its strobe for one cycle. All flags are registered, so an event at a clock edge is visible on `flags_o` from that edge onward. Data is read as signed Q1.19 two's complement, so one quarter is `0x20000`.

The packed flag word is laid out as follows: bit 0 zero, bit 1 negative, bit 2 carry, bit 3 overflow, bit 4 sticky overflow, bit 5 sticky limiting, bit 6 sticky scaling, bit 7 quotient.

Top module: `dsp_status_flags`

## Requirements
- R1: After reset every bit of `flags_o` (bits 7..0) is 0.
- R2: On a result strobe, zero (bit 0) becomes 1 if all 20 bits of `res_data` are 0, and becomes 0 otherwise.
- R3: On a result strobe, negative (bit 1) takes the value of `res_data[19]`.
- R4: On a result strobe, carry (bit 2) takes `res_carry` and overflow (bit 3) takes `res_ovf`, including for compares. Without a result strobe, bits 3..0 keep their value, even during shifter transfers.
- R5: Sticky overflow (bit 4) becomes 1 on a result strobe with `res_ovf` set, unless `res_is_cmp` is also set.
- R6: Sticky limiting (bit 5) becomes 1 on a result strobe with `res_limit`, or on a shifter strobe with `shf_limit`.
- R7: Sticky scaling (bit 6) becomes 1 on a shifter strobe whose signed data has magnitude strictly above 0.25. The values `0x20000` (+0.25) and `0xE0000` (-0.25) do not set it. The values `0x20001`, `0xDFFFF` and `0x80000` do set it.
- R8: Bits 6..4 stay set until `sticky_clr` is asserted; a cycle with `sticky_clr` and no setting event clears them.
- R9: When `sticky_clr` and an event that sets a sticky bit happen in the same cycle, that sticky bit ends up 1.
- R10: On `quo_valid`, quotient (bit 7) takes `quo_bit`; otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Arithmetic result strobe |
| res_data | input | 20 | Destination value of the result |
| res_carry | input | 1 | Carry, borrow or shifted-out bit |
| res_ovf | input | 1 | Result not representable |
| res_limit | input | 1 | Arithmetic unit saturated the result |
| res_is_cmp | input | 1 | Result came from a compare operation |
| shf_valid | input | 1 | Data shifter transfer strobe |
| shf_data | input | 20 | Word passing through the shifter |
| shf_limit | input | 1 | Shifter saturated the word |
| sticky_clr | input | 1 | Clear the three sticky flags |
| quo_valid | input | 1 | Divide iteration strobe |
| quo_bit | input | 1 | New quotient bit |
| flags_o | output | 8 | Packed flag word |

## Verification
The hardest case to reach is a clear command arriving in the same cycle as the event it would erase. The case gets harder when a second sticky bit, with no event in that cycle, must still clear. The stimulus first sets both sticky limiting and sticky overflow. It then asserts the clear together with a shifter word just past minus one quarter, and together with an overflowing non-compare result. This shows that one bit survives while another drops. The scaling boundaries are driven separately at exactly plus and minus one quarter, one step beyond, and the most negative code.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  localparam int FLAG_W = 8;
  localparam int F_ZERO = 0;
  localparam int F_NEG  = 1;
  localparam int F_CARRY = 2;
  localparam int F_OVF  = 3;
  localparam int F_SOVF = 4;
  localparam int F_SLIM = 5;
  localparam int F_SSCL = 6;
  localparam int F_QUO  = 7;
  localparam int N_STICKY = 3;
endpackage

// File: rtl/sflag_arith.sv
module sflag_arith #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] data,
  input  logic         carry,
  input  logic         ovf,
  output logic         z,
  output logic         n,
  output logic         c,
  output logic         v
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      z <= 1'b0;
      n <= 1'b0;
      c <= 1'b0;
      v <= 1'b0;
    end else if (load) begin
      z <= (data == '0);
      n <= data[W-1];
      c <= carry;
      v <= ovf;
    end
  end
endmodule

// File: rtl/sflag_quarter.sv
module sflag_quarter #(
  parameter int W = 20
) (
  input  logic [W-1:0] data,
  output logic         above
);
  localparam logic [W-1:0] QTR     = {2'b00, 1'b1, {(W-3){1'b0}}};
  localparam logic [W-1:0] NEG_QTR = {3'b111, {(W-3){1'b0}}};

  // Range compare on the raw code: no negation, so the most negative
  // code needs no special case.
  always_comb begin
    if (data[W-1]) above = (data < NEG_QTR);
    else           above = (data > QTR);
  end
endmodule

// File: rtl/sflag_sticky.sv
module sflag_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr)    q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/dsp_status_flags.sv
module dsp_status_flags
  import sflag_pkg::*;
#(
  parameter int DATA_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_carry,
  input  logic              res_ovf,
  input  logic              res_limit,
  input  logic              res_is_cmp,
  input  logic              shf_valid,
  input  logic [DATA_W-1:0] shf_data,
  input  logic              shf_limit,
  input  logic              sticky_clr,
  input  logic              quo_valid,
  input  logic              quo_bit,
  output logic [FLAG_W-1:0] flags_o
);
  logic z, n, c, v;
  logic shf_big;
  logic quo_q;
  logic [N_STICKY-1:0] st_set, st_q;

  sflag_arith #(.W(DATA_W)) u_arith (
    .clk(clk), .rst_n(rst_n), .load(res_valid), .data(res_data),
    .carry(res_carry), .ovf(res_ovf), .z(z), .n(n), .c(c), .v(v)
  );

  sflag_quarter #(.W(DATA_W)) u_qtr (.data(shf_data), .above(shf_big));

  // sticky order: 0 overflow, 1 limiting, 2 scaling
  always_comb begin
    st_set[0] = res_valid & res_ovf & ~res_is_cmp;
    st_set[1] = (res_valid & res_limit) | (shf_valid & shf_limit);
    st_set[2] = shf_valid & shf_big;
  end

  sflag_sticky #(.N(N_STICKY)) u_sticky (
    .clk(clk), .rst_n(rst_n), .clr(sticky_clr), .set(st_set), .q(st_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         quo_q <= 1'b0;
    else if (quo_valid) quo_q <= quo_bit;
  end

  always_comb begin
    flags_o          = '0;
    flags_o[F_ZERO]  = z;
    flags_o[F_NEG]   = n;
    flags_o[F_CARRY] = c;
    flags_o[F_OVF]   = v;
    flags_o[F_SOVF]  = st_q[0];
    flags_o[F_SLIM]  = st_q[1];
    flags_o[F_SSCL]  = st_q[2];
    flags_o[F_QUO]   = quo_q;
  end
endmodule

// File: rtl/dsp_status_flags_chk.sv
module dsp_status_flags_chk #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         res_valid,
  input logic [W-1:0] res_data,
  input logic         res_ovf,
  input logic         res_is_cmp,
  input logic         shf_valid,
  input logic         shf_limit,
  input logic         sticky_clr,
  input logic         quo_valid,
  input logic         quo_bit,
  input logic [7:0]   flags
);
  a_r2_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (flags[0] == ($past(res_data) == '0)));
  a_r3_negative: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (flags[1] == $past(res_data[W-1])));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(flags[3:0]));
  a_r5_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ovf && !res_is_cmp) |=> flags[4]);
  a_r8_sticky_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !sticky_clr |=> ((flags[6:4] & $past(flags[6:4])) == $past(flags[6:4])));
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_clr && shf_valid && shf_limit) |=> flags[5]);
  a_r10_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    quo_valid |=> (flags[7] == $past(quo_bit)));
  a_r10_quo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !quo_valid |=> $stable(flags[7]));
endmodule

bind dsp_status_flags dsp_status_flags_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
  .res_ovf(res_ovf), .res_is_cmp(res_is_cmp), .shf_valid(shf_valid),
  .shf_limit(shf_limit), .sticky_clr(sticky_clr), .quo_valid(quo_valid),
  .quo_bit(quo_bit), .flags(flags_o)
);

// File: tb/tb_dsp_status_flags.sv
`timescale 1ns/1ps
module tb_dsp_status_flags;
  logic clk = 1'b0;
  logic rst_n;
  logic res_valid, res_carry, res_ovf, res_limit, res_is_cmp;
  logic [19:0] res_data, shf_data;
  logic shf_valid, shf_limit, sticky_clr, quo_valid, quo_bit;
  logic [7:0] flags_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dsp_status_flags dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .res_carry(res_carry), .res_ovf(res_ovf), .res_limit(res_limit),
    .res_is_cmp(res_is_cmp), .shf_valid(shf_valid), .shf_data(shf_data),
    .shf_limit(shf_limit), .sticky_clr(sticky_clr), .quo_valid(quo_valid),
    .quo_bit(quo_bit), .flags_o(flags_o)
  );

  typedef struct packed {
    logic        rv;
    logic [19:0] rd;
    logic        rc, ro, rl, rcmp;
    logic        sv;
    logic [19:0] sd;
    logic        sl;
    logic        clr;
    logic        qv, qb;
    logic [7:0]  exp;
  } vec_t;

  // flag bits: 7 Q, 6 SS, 5 SL, 4 SV, 3 V, 2 C, 1 N, 0 Z
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 20'h00000, 1'b0,1'b0,1'b0,1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0,1'b0, 8'h01}, // R2
    '{1'b1, 20'h80001, 1'b1,1'b0,1'b0,1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0,1'b0, 8'h06}, // R3 R4
    '{1'b1, 20'h12345, 1'b0,1'b1,1'b0,1'b1, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0,1'b0, 8'h08}, // R5 cmp
    '{1'b1, 20'h12345, 1'b0,1'b1,1'b0,1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0,1'b0, 8'h18}, // R5
    '{1'b0, 20'h00000, 1'b0,1'b0,1'b0,1'b0, 1'b1, 20'h20001, 1'b0, 1'b0, 1'b0,1'b0, 8'h58}, // R7 R4
    '{1'b1, 20'h00000, 1'b0,1'b0,1'b1,1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0,1'b0, 8'h71}, // R6
    '{1'b0, 20'h00000, 1'b0,1'b0,1'b0,1'b0, 1'b0, 20'h0, 1'b0, 1'b1, 1'b0,1'b0, 8'h01}, // R8
    '{1'b0, 20'h00000, 1'b0,1'b0,1'b0,1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1'b1,1'b1, 8'h81}, // R10
    '{1'b0, 20'h00000, 1'b0,1'b0,1'b0,1'b0, 1'b1, 20'h20000, 1'b1, 1'b0, 1'b0,1'b0, 8'hA1}, // R6 R7
    '{1'b0, 20'h00000, 1'b0,1'b0,1'b0,1'b0, 1'b1, 20'hDFFFF, 1'b0, 1'b1, 1'b0,1'b0, 8'hC1}, // R9
    '{1'b1, 20'h7FFFF, 1'b0,1'b0,1'b0,1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1'b1,1'b0, 8'h40}, // R2 R10
    '{1'b0, 20'h00000, 1'b0,1'b0,1'b0,1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0,1'b0, 8'h40}  // R8 idle
  };

  task automatic idle();
    res_valid = 0; res_data = '0; res_carry = 0; res_ovf = 0; res_limit = 0;
    res_is_cmp = 0; shf_valid = 0; shf_data = '0; shf_limit = 0;
    sticky_clr = 0; quo_valid = 0; quo_bit = 0;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: flags actual %02h expected %02h", req, act, exp);
    end
  endtask

  // drive at negedge, one edge, sample at the following negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    step();
    step();
    rst_n = 1;
  endtask

  task automatic shift_in(logic [19:0] d, logic lim, logic clr);
    idle();
    shf_valid = 1; shf_data = d; shf_limit = lim; sticky_clr = clr;
    step();
  endtask

  initial begin
    idle();
    rst_n = 0;
    do_reset();
    check("R1 reset", flags_o, 8'h00);

    for (int i = 0; i < NV; i++) begin
      res_valid = VEC[i].rv; res_data = VEC[i].rd; res_carry = VEC[i].rc;
      res_ovf = VEC[i].ro; res_limit = VEC[i].rl; res_is_cmp = VEC[i].rcmp;
      shf_valid = VEC[i].sv; shf_data = VEC[i].sd; shf_limit = VEC[i].sl;
      sticky_clr = VEC[i].clr; quo_valid = VEC[i].qv; quo_bit = VEC[i].qb;
      step();
      idle();
      check($sformatf("R2-table vector %0d", i), flags_o, VEC[i].exp);
    end

    do_reset();
    check("R1 reset after activity", flags_o, 8'h00);

    shift_in(20'h20000, 1'b0, 1'b0);
    check("R7 plus quarter no SS", flags_o, 8'h00);
    shift_in(20'hE0000, 1'b0, 1'b0);
    check("R7 minus quarter no SS", flags_o, 8'h00);
    shift_in(20'h80000, 1'b0, 1'b0);
    check("R7 most negative sets SS", flags_o, 8'h40);
    shift_in(20'h00000, 1'b0, 1'b1);
    check("R8 clear with no event", flags_o, 8'h00);

    // set SL and SV, then clear alongside SS and SV events: SL must drop
    shift_in(20'h00000, 1'b1, 1'b0);
    idle();
    res_valid = 1; res_data = 20'h00100; res_ovf = 1;
    step();
    check("R5 SV set with SL", flags_o, 8'h38);
    idle();
    res_valid = 1; res_data = 20'h00100; res_ovf = 1;
    shf_valid = 1; shf_data = 20'hDFFFF; sticky_clr = 1;
    step();
    check("R9 events win, SL cleared", flags_o, 8'h58);
    idle();
    shf_valid = 1; shf_data = 20'h00001; shf_limit = 1;
    step();
    check("R4 shifter leaves V and Z", flags_o, 8'h78);

    idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule